// File: doc/BRIEF.md
# Masked Set/Clear Interrupt Controller

This block gathers event pulses and levels from the rest of a contactless-reader datapath into two request registers. These are the main register and the auxiliary register. It masks them with two enable registers and drives one interrupt pin. The event sources are the transmitter, the receiver, the command sequencer, the FIFO alert levels, the error flags, the timer, the CRC engine and an external input pin. The sources themselves are not part of this block. Once an event is latched, it stays set until the host clears it.

The host writes one byte to one of four registers. The two-bit address selects the register: 0 is main request, 1 is auxiliary request, 2 is main enable and 3 is auxiliary enable. A write to a request register is masked. Bit 7 of the data chooses between setting and clearing the bits marked with 1, and every unmarked bit keeps its value. Enable registers are written directly. Bit 7 of the main enable register inverts the pin. Bit 7 of the auxiliary enable register selects a push-pull or an open-drain drive for the pin. All four registers are visible as outputs.

Top module: `intr_ctrl`

## Requirements
- R1: After reset the registers read as follows: main request 0x14, main enable 0x80, auxiliary request 0x00 and auxiliary enable 0x00.
- R2: A write to a request register with data bit 7 = 1 sets each implemented bit whose data bit is 1. All other bits are unchanged.
- R3: A write to a request register with data bit 7 = 0 clears each bit whose data bit is 1. All other bits are unchanged.
- R4: If an event for a request bit arrives in the same cycle as a host clear of that bit, the bit ends up set.
- R5: `irq_status` is the OR of every request bit ANDed with its enable bit. The main register has tx=6, rx=5, idle=4, high alert=3, low alert=2, error=1 and timer=0. The auxiliary register has external pin=4 and CRC=2.
- R6: The conditioned request is `irq_status` XOR main-enable bit 7.
- R7: When auxiliary-enable bit 7 = 1 (push-pull), `irq_pin_oe`=1 and `irq_pin_o` equals the conditioned request. When it is 0 (open-drain), `irq_pin_o`=0 and `irq_pin_oe`=1 only while the conditioned request is 0.
- R8: A pulse on `ev_cmd_idle` sets the idle bit when `cmd_idle_cause` is 0 (the command finished by itself) or 1 (an unknown command was forced to idle). It does not set the bit when the cause is 2 (the host started idle).
- R9: While a FIFO alert level is high, its request bit is set. The bit stays set after the level falls, until the host clears it.
- R10: Any nonzero `err_flags` sets the error bit. Pulses on `ev_timer_zero`, `ev_tx_done`, `ev_rx_done` and `ev_crc_done` set their own bits.
- R11: Both a rising and a falling edge on `ext_pin` set the external-pin bit, SYNC_STAGES+1 clock edges after the pin is sampled.
- R12: Bits that are not implemented always read 0. These are main request bit 7, auxiliary request bits other than 4 and 2, and auxiliary enable bits other than 7, 4 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select: 0 main request, 1 auxiliary request, 2 main enable, 3 auxiliary enable |
| host_wdata | input | 8 | Host write data |
| ev_tx_done | input | 1 | Pulse: last bit was transmitted |
| ev_rx_done | input | 1 | Pulse: end of a valid received stream |
| ev_cmd_idle | input | 1 | Pulse: command sequencer returned to idle |
| cmd_idle_cause | input | 2 | Reason for the return to idle: 0 self, 1 unknown, 2 host |
| fifo_hi_alert | input | 1 | FIFO high-alert level |
| fifo_lo_alert | input | 1 | FIFO low-alert level |
| err_flags | input | ERR_W | Error flag vector |
| ev_timer_zero | input | 1 | Pulse: timer reached zero |
| ev_crc_done | input | 1 | Pulse: CRC engine finished |
| ext_pin | input | 1 | Asynchronous external input pin |
| req_main | output | 8 | Main request register |
| req_aux | output | 8 | Auxiliary request register |
| en_main | output | 8 | Main enable register |
| en_aux | output | 8 | Auxiliary enable register |
| irq_status | output | 1 | Combined masked request |
| irq_pin_o | output | 1 | Interrupt pin output value |
| irq_pin_oe | output | 1 | Interrupt pin output enable |

## Verification
Two things can fall in the same cycle: a host clear of a request bit and the event that sets that bit. The collision is provoked on purpose for the transmit bit and for the FIFO alert bit. The alert case holds the level high while a clear is written. It is also provoked repeatedly during a random phase in which writes and event pulses overlap freely. A behavioural reference model runs beside the design. Every cycle it predicts all four registers and the pin, with the rule that the event wins. Any difference in the bit after the collision is reported.

// File: rtl/intr_pkg.sv
`timescale 1ns/1ps
package intr_pkg;
  localparam int REG_W = 8;
  localparam int CTL_BIT = REG_W - 1;

  typedef enum logic [1:0] {
    ADDR_REQ_MAIN = 2'd0,
    ADDR_REQ_AUX  = 2'd1,
    ADDR_EN_MAIN  = 2'd2,
    ADDR_EN_AUX   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    CAUSE_SELF    = 2'd0,
    CAUSE_UNKNOWN = 2'd1,
    CAUSE_HOST    = 2'd2,
    CAUSE_RSVD    = 2'd3
  } idle_cause_e;

  // main request bit positions
  localparam int B_TX   = 6;
  localparam int B_RX   = 5;
  localparam int B_IDLE = 4;
  localparam int B_HI   = 3;
  localparam int B_LO   = 2;
  localparam int B_ERR  = 1;
  localparam int B_TMR  = 0;
  // auxiliary request bit positions
  localparam int B_EXT  = 4;
  localparam int B_CRC  = 2;

  localparam logic [REG_W-1:0] IMPL_REQ_MAIN = 8'h7F;
  localparam logic [REG_W-1:0] IMPL_REQ_AUX  = 8'h14;
  localparam logic [REG_W-1:0] IMPL_EN_MAIN  = 8'hFF;
  localparam logic [REG_W-1:0] IMPL_EN_AUX   = 8'h94;
  localparam logic [REG_W-1:0] RST_REQ_MAIN  = 8'h14;
  localparam logic [REG_W-1:0] RST_REQ_AUX   = 8'h00;
  localparam logic [REG_W-1:0] RST_EN_MAIN   = 8'h80;
  localparam logic [REG_W-1:0] RST_EN_AUX    = 8'h00;
endpackage

// File: rtl/intr_req_reg.sv
`timescale 1ns/1ps
module intr_req_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  logic         ctl;
  logic [W-1:0] mark;
  logic [W-1:0] evt_m;
  logic [W-1:0] upd;

  assign ctl   = wdata[W-1];
  assign mark  = wdata & IMPL;
  assign evt_m = evt & IMPL;

  always_comb begin
    upd = q;
    if (wr) upd = ctl ? (q | mark) : (q & ~mark);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST & IMPL;
    else     q <= (upd | evt_m) & IMPL;
  end

  // R2
  set_marked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && ctl) |=> ((q & $past(mark)) == $past(mark)));
  // R3
  clear_marked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !ctl) |=> ((q & $past(mark) & ~$past(evt_m)) == '0));
  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_m != '0) |=> ((q & $past(evt_m)) == $past(evt_m)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr && evt_m == '0) |=> $stable(q));
endmodule

// File: rtl/intr_en_reg.sv
`timescale 1ns/1ps
module intr_en_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST & IMPL;
    else if (wr) q <= wdata & IMPL;
  end

  // R12
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> ((q & ~IMPL) == '0 && q == ($past(wdata) & IMPL)));
endmodule

// File: rtl/intr_edge_sync.sv
`timescale 1ns/1ps
module intr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic edge_pulse
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign edge_pulse = chain[STAGES-1] ^ prev;

  // R11
  edge_from_change_chk: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |=> (prev != $past(prev)));
endmodule

// File: rtl/intr_out_cond.sv
`timescale 1ns/1ps
module intr_out_cond
  import intr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] req_main,
  input  logic [REG_W-1:0] en_main,
  input  logic [REG_W-1:0] req_aux,
  input  logic [REG_W-1:0] en_aux,
  output logic             status,
  output logic             pin_o,
  output logic             pin_oe
);
  logic cond;
  logic push_pull;

  assign status    = |(req_main & en_main & IMPL_REQ_MAIN) |
                     |(req_aux  & en_aux  & IMPL_REQ_AUX);
  assign cond      = status ^ en_main[CTL_BIT];
  assign push_pull = en_aux[CTL_BIT];

  always_comb begin
    if (push_pull) begin
      pin_o  = cond;
      pin_oe = 1'b1;
    end else begin
      pin_o  = 1'b0;
      pin_oe = ~cond;
    end
  end

  // R5
  no_enabled_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((req_main & en_main[CTL_BIT-1:0]) == '0 && (req_aux[B_EXT] & en_aux[B_EXT]) == 1'b0 &&
     (req_aux[B_CRC] & en_aux[B_CRC]) == 1'b0) |-> !status);
  // R7
  push_pull_drive_chk: assert property (@(posedge clk) disable iff (rst)
    en_aux[CTL_BIT] |-> pin_oe);
  // R7
  open_drain_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en_aux[CTL_BIT] |-> (!pin_o && (pin_oe != (status ^ en_main[CTL_BIT]))));
endmodule

// File: rtl/intr_ctrl.sv
`timescale 1ns/1ps
module intr_ctrl
  import intr_pkg::*;
#(
  parameter int ERR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [1:0]       host_addr,
  input  logic [REG_W-1:0] host_wdata,
  input  logic             ev_tx_done,
  input  logic             ev_rx_done,
  input  logic             ev_cmd_idle,
  input  logic [1:0]       cmd_idle_cause,
  input  logic             fifo_hi_alert,
  input  logic             fifo_lo_alert,
  input  logic [ERR_W-1:0] err_flags,
  input  logic             ev_timer_zero,
  input  logic             ev_crc_done,
  input  logic             ext_pin,
  output logic [REG_W-1:0] req_main,
  output logic [REG_W-1:0] req_aux,
  output logic [REG_W-1:0] en_main,
  output logic [REG_W-1:0] en_aux,
  output logic             irq_status,
  output logic             irq_pin_o,
  output logic             irq_pin_oe
);
  logic [REG_W-1:0] evt_main;
  logic [REG_W-1:0] evt_aux;
  logic             ext_edge;
  logic             idle_set;
  logic [3:0]       wr_sel;

  always_comb begin
    wr_sel = '0;
    if (host_wr) wr_sel[host_addr] = 1'b1;
  end

  assign idle_set = ev_cmd_idle && (idle_cause_e'(cmd_idle_cause) != CAUSE_HOST);

  always_comb begin
    evt_main         = '0;
    evt_main[B_TX]   = ev_tx_done;
    evt_main[B_RX]   = ev_rx_done;
    evt_main[B_IDLE] = idle_set;
    evt_main[B_HI]   = fifo_hi_alert;
    evt_main[B_LO]   = fifo_lo_alert;
    evt_main[B_ERR]  = |err_flags;
    evt_main[B_TMR]  = ev_timer_zero;
    evt_aux          = '0;
    evt_aux[B_EXT]   = ext_edge;
    evt_aux[B_CRC]   = ev_crc_done;
  end

  intr_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .pin(ext_pin), .edge_pulse(ext_edge)
  );

  intr_req_reg #(.W(REG_W), .IMPL(IMPL_REQ_MAIN), .RST(RST_REQ_MAIN)) u_req_main (
    .clk(clk), .rst(rst), .wr(wr_sel[ADDR_REQ_MAIN]), .wdata(host_wdata),
    .evt(evt_main), .q(req_main)
  );

  intr_req_reg #(.W(REG_W), .IMPL(IMPL_REQ_AUX), .RST(RST_REQ_AUX)) u_req_aux (
    .clk(clk), .rst(rst), .wr(wr_sel[ADDR_REQ_AUX]), .wdata(host_wdata),
    .evt(evt_aux), .q(req_aux)
  );

  intr_en_reg #(.W(REG_W), .IMPL(IMPL_EN_MAIN), .RST(RST_EN_MAIN)) u_en_main (
    .clk(clk), .rst(rst), .wr(wr_sel[ADDR_EN_MAIN]), .wdata(host_wdata), .q(en_main)
  );

  intr_en_reg #(.W(REG_W), .IMPL(IMPL_EN_AUX), .RST(RST_EN_AUX)) u_en_aux (
    .clk(clk), .rst(rst), .wr(wr_sel[ADDR_EN_AUX]), .wdata(host_wdata), .q(en_aux)
  );

  intr_out_cond u_out (
    .clk(clk), .rst(rst),
    .req_main(req_main), .en_main(en_main), .req_aux(req_aux), .en_aux(en_aux),
    .status(irq_status), .pin_o(irq_pin_o), .pin_oe(irq_pin_oe)
  );

  // R8
  host_idle_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_cmd_idle && cmd_idle_cause == 2'd2 && !req_main[B_IDLE] &&
     !(host_wr && host_addr == 2'd0)) |=> !req_main[B_IDLE]);
  // R10
  err_any_set_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flags != '0) |=> req_main[B_ERR]);
  // R1
  first_cycle_reset_chk: assert property (@(posedge clk)
    rst |=> (en_main == RST_EN_MAIN && en_aux == RST_EN_AUX));
endmodule

// File: tb/test_intr_ctrl.sv
`timescale 1ns/1ps
module test_intr_ctrl;
  localparam int ERR_W = 8;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic ev_tx_done = 0, ev_rx_done = 0, ev_cmd_idle = 0;
  logic [1:0] cmd_idle_cause = '0;
  logic fifo_hi_alert = 0, fifo_lo_alert = 0;
  logic [ERR_W-1:0] err_flags = '0;
  logic ev_timer_zero = 0, ev_crc_done = 0, ext_pin = 0;
  logic [7:0] req_main, req_aux, en_main, en_aux;
  logic irq_status, irq_pin_o, irq_pin_oe;

  always #2 clk = ~clk;

  intr_ctrl #(.ERR_W(ERR_W), .SYNC_STAGES(SYNC)) i_intr_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_cmd_idle(ev_cmd_idle),
    .cmd_idle_cause(cmd_idle_cause), .fifo_hi_alert(fifo_hi_alert), .fifo_lo_alert(fifo_lo_alert),
    .err_flags(err_flags), .ev_timer_zero(ev_timer_zero), .ev_crc_done(ev_crc_done),
    .ext_pin(ext_pin), .req_main(req_main), .req_aux(req_aux), .en_main(en_main),
    .en_aux(en_aux), .irq_status(irq_status), .irq_pin_o(irq_pin_o), .irq_pin_oe(irq_pin_oe)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit started = 0;
  bit done = 0;

  // behavioural reference model
  logic [7:0] m_rm, m_ra, m_em, m_ea;
  bit pin_hist[$];

  always @(posedge clk) begin
    logic [7:0] ev_m, ev_a, mk;
    bit e;
    started = 1;
    if (rst) begin
      m_rm = 8'h14; m_ra = 8'h00; m_em = 8'h80; m_ea = 8'h00;
      pin_hist.delete();
      for (int i = 0; i <= SYNC; i++) pin_hist.push_front(1'b0);
    end else begin
      e = pin_hist[SYNC-1] ^ pin_hist[SYNC];
      pin_hist.push_front(ext_pin);
      void'(pin_hist.pop_back());
      ev_m = 8'h00;
      if (ev_tx_done)    ev_m = ev_m | 8'h40;
      if (ev_rx_done)    ev_m = ev_m | 8'h20;
      if (ev_cmd_idle && cmd_idle_cause != 2) ev_m = ev_m | 8'h10;
      if (fifo_hi_alert) ev_m = ev_m | 8'h08;
      if (fifo_lo_alert) ev_m = ev_m | 8'h04;
      if (err_flags != 0) ev_m = ev_m | 8'h02;
      if (ev_timer_zero) ev_m = ev_m | 8'h01;
      ev_a = 8'h00;
      if (e)           ev_a = ev_a | 8'h10;
      if (ev_crc_done) ev_a = ev_a | 8'h04;
      if (host_wr) begin
        case (host_addr)
          2'd0: begin mk = host_wdata & 8'h7F;
                  m_rm = host_wdata[7] ? (m_rm | mk) : (m_rm & ~mk); end
          2'd1: begin mk = host_wdata & 8'h14;
                  m_ra = host_wdata[7] ? (m_ra | mk) : (m_ra & ~mk); end
          2'd2: m_em = host_wdata;
          default: m_ea = host_wdata & 8'h94;
        endcase
      end
      m_rm = m_rm | ev_m;
      m_ra = m_ra | ev_a;
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit st, cond, po, poe;
    if (started && !done) begin
      st   = ((m_rm & m_em & 8'h7F) != 0) || ((m_ra & m_ea & 8'h14) != 0);
      cond = st ^ m_em[7];
      po   = m_ea[7] ? cond : 1'b0;
      poe  = m_ea[7] ? 1'b1 : !cond;
      cmp("req_main", req_main, m_rm);
      cmp("req_aux", req_aux, m_ra);
      cmp("en_main", en_main, m_em);
      cmp("en_aux", en_aux, m_ea);
      cmp("irq_status", irq_status, st);
      cmp("irq_pin_o", irq_pin_o, po);
      cmp("irq_pin_oe", irq_pin_oe, poe);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    step();
    host_wr = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) step();
    rst = 0;
    step();
    cmp("reset req_main", req_main, 8'h14);
    cmp("reset en_main", en_main, 8'h80);
    cur_req = "R2";
    wr(2'd0, 8'hC1); step();
    wr(2'd1, 8'h94); step();
    cur_req = "R12";
    wr(2'd0, 8'hFF); wr(2'd3, 8'hFF); wr(2'd1, 8'hEB); step();
    cmp("unimpl aux", req_aux & 8'hEB, 0);
    cur_req = "R3";
    wr(2'd0, 8'h10); wr(2'd0, 8'h41); wr(2'd1, 8'h04); step();
    cur_req = "R5";
    wr(2'd3, 8'h00); wr(2'd0, 8'h7F); wr(2'd1, 8'h14);
    for (int i = 0; i < 7; i++) begin
      wr(2'd2, 8'(1 << i)); wr(2'd0, 8'h80 | 8'(1 << i)); step();
      wr(2'd0, 8'(1 << i)); step();
    end
    wr(2'd2, 8'h00); wr(2'd3, 8'h10); wr(2'd1, 8'h94); step();
    wr(2'd3, 8'h04); step(); wr(2'd1, 8'h14); step();
    cur_req = "R6";
    wr(2'd2, 8'h80); step(); wr(2'd0, 8'h80 | 8'h40); wr(2'd2, 8'hC0); step();
    wr(2'd2, 8'h40); step();
    cur_req = "R7";
    wr(2'd3, 8'h80); step(); wr(2'd2, 8'hC0); step();
    wr(2'd3, 8'h00); step(); wr(2'd2, 8'h40); step();
    cur_req = "R4";
    host_wr = 1; host_addr = 2'd0; host_wdata = 8'h40; ev_tx_done = 1; step();
    host_wr = 0; ev_tx_done = 0; step();
    cmp("tx after collision", req_main[6], 1);
    fifo_hi_alert = 1; wr(2'd0, 8'h08); step();
    cur_req = "R9";
    fifo_hi_alert = 0; step(); step();
    cmp("hi latched", req_main[3], 1);
    wr(2'd0, 8'h7F); fifo_lo_alert = 1; step(); fifo_lo_alert = 0; step(); step();
    wr(2'd0, 8'h04); step();
    cur_req = "R8";
    for (int c = 0; c < 4; c++) begin
      wr(2'd0, 8'h10);
      ev_cmd_idle = 1; cmd_idle_cause = 2'(c); step();
      ev_cmd_idle = 0; step();
      cmp("idle by cause", req_main[4], (c == 2) ? 0 : 1);
    end
    cur_req = "R10";
    wr(2'd0, 8'h7F); wr(2'd1, 8'h14); wr(2'd2, 8'h7F); wr(2'd3, 8'h14);
    for (int i = 0; i < ERR_W; i++) begin
      err_flags = ERR_W'(1) << i; step(); err_flags = '0; step();
      wr(2'd0, 8'h02);
    end
    ev_timer_zero = 1; step(); ev_timer_zero = 0;
    ev_rx_done = 1; step(); ev_rx_done = 0;
    ev_tx_done = 1; step(); ev_tx_done = 0;
    ev_crc_done = 1; step(); ev_crc_done = 0; step();
    cmp("crc bit", req_aux[2], 1);
    cur_req = "R11";
    wr(2'd1, 8'h14);
    ext_pin = 1; repeat (5) step();
    cmp("ext rise", req_aux[4], 1);
    wr(2'd1, 8'h10); repeat (3) step();
    ext_pin = 0; repeat (5) step();
    cmp("ext fall", req_aux[4], 1);
    wr(2'd1, 8'h10);
    ext_pin = 1; step(); ext_pin = 0; repeat (5) step();
    cur_req = "R4";
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      r = $urandom;
      host_wr = (r[3:0] < 5); host_addr = r[5:4]; host_wdata = r[13:6];
      ev_tx_done = r[14] & r[15]; ev_rx_done = r[16] & r[17];
      ev_cmd_idle = r[18] & r[19]; cmd_idle_cause = r[21:20];
      fifo_hi_alert = r[22] & r[23]; fifo_lo_alert = r[24] & r[25];
      err_flags = (r[26] & r[27]) ? ERR_W'(r[31:24]) : '0;
      ev_timer_zero = r[28] & r[29]; ev_crc_done = r[30] & r[31];
      if (r[7:4] == 0) ext_pin = ~ext_pin;
      step();
    end
    host_wr = 0; ev_tx_done = 0; ev_rx_done = 0; ev_cmd_idle = 0; fifo_hi_alert = 0;
    fifo_lo_alert = 0; err_flags = '0; ev_timer_zero = 0; ev_crc_done = 0;
    repeat (4) step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule